// File: doc/BRIEF.md
# Converter Link Transmit Sequencer

This block is the link-layer controller on the transmit side of a serial converter link. It works on characters before line coding. In every clock cycle it produces one 8-bit character and a flag that marks the character as a control (K) code. The receiver asks for resynchronisation by holding an active-low sync line low. While that line is low, the block sends a stream of comma characters, which lets the receiver find word boundaries.

When sync is released, the block waits for the next local multiframe boundary. It then sends a lane alignment sequence of several multiframes. The second multiframe of that sequence carries the link configuration bytes. After the last alignment multiframe, the block passes user data through as plain data characters. If sync drops at any point, the block goes straight back to commas and the whole handshake runs again.

A multiframe holds `FRAMES_PER_MF * OCTETS_PER_FRAME` octet slots. The boundary strobe marks slot 0, and the block counts the slots between strobes. The character chosen for the slot of cycle t is registered and appears on the outputs in cycle t+1.

Top module: `lane_tx_sequencer`

## Requirements
- R1: When `sync_n` is sampled low in any state, the next cycle shows `tx_char`=0xBC with `tx_is_k`=1.
- R2: During reset and in the first cycle after it, the outputs are 0xBC with `tx_is_k`=1.
- R3: After `sync_n` is first sampled high, commas continue. The alignment sequence starts in the slot of the first `lmfc_strobe` sampled strictly after that cycle. A strobe in the same cycle as the first high sample does not count.
- R4: The alignment sequence spans exactly `ILA_MULTIFRAMES` multiframes. This parameter must be at least 4. The slot right after the sequence is no longer an alignment character.
- R5: Each alignment multiframe has 0x1C (K) in slot 0 and 0x7C (K) in its last slot.
- R6: In alignment multiframes other than the second, every other slot p carries data value p mod 256 with `tx_is_k`=0.
- R7: In the second alignment multiframe, slot 1 is 0x9C (K). Slots 2 to 2+CFG_BYTES-1 carry configuration byte i = `cfg_bytes[8i+7:8i]` in slot 2+i. The remaining slots before the last carry filler value p with `tx_is_k`=0.
- R8: After the sequence, from the next multiframe boundary on, each slot outputs `user_data` with `tx_is_k`=0 when `user_valid` is 1, and 0x00 with `tx_is_k`=0 when it is 0.
- R9: A sync drop during the alignment sequence or during user data gives commas from the next cycle. After sync is released again, the full sequence is repeated from its first multiframe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_n | input | 1 | Active-low resynchronisation request from the receiver |
| lmfc_strobe | input | 1 | High in slot 0 of each local multiframe |
| frame_start | input | 1 | High in the first slot of each frame |
| user_data | input | 8 | User octet for the current slot |
| user_valid | input | 1 | Marks `user_data` as valid |
| cfg_bytes | input | CFG_BYTES*8 | Link configuration bytes, byte i in bits 8i+7:8i |
| tx_char | output | 8 | Character for the encoder |
| tx_is_k | output | 1 | Character is a control code |

## Verification
The bench builds the block with two octets per frame, five frames per multiframe, four alignment multiframes and four configuration bytes. This gives a ten-slot multiframe in which the configuration occupies slots 2 to 5 and counter filler occupies slots 6 to 8, so both halves of R7 are visible. Short multiframes let the bench cover several things within a few thousand cycles:
- sync released exactly on a boundary, and one cycle before one;
- sync dropped in the middle of the alignment sequence and in the middle of user data;
- a restart with a different configuration.

// File: rtl/lts_pkg.sv
package lts_pkg;

    typedef enum logic [1:0] {
        ST_CGS  = 2'd0,
        ST_WAIT = 2'd1,
        ST_ILA  = 2'd2,
        ST_DATA = 2'd3
    } lts_state_e;

    localparam logic [7:0] CH_COMMA = 8'hBC;
    localparam logic [7:0] CH_SOS   = 8'h1C;
    localparam logic [7:0] CH_LANE  = 8'h7C;
    localparam logic [7:0] CH_CFG   = 8'h9C;

endpackage

// File: rtl/lts_mf_position.sv
module lts_mf_position #(
    parameter int MF_LEN = 16,
    localparam int IW = (MF_LEN > 1) ? $clog2(MF_LEN) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lmfc_strobe,
    output logic [IW-1:0] idx_o
);
    localparam logic [IW-1:0] LAST = IW'(MF_LEN - 1);

    logic [IW-1:0] pos_d, pos_q;

    always_comb begin
        idx_o = lmfc_strobe ? '0 : pos_q;
        pos_d = (idx_o == LAST) ? '0 : idx_o + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    // R6: slot after a boundary is slot 1 unless another boundary arrives
    p_idx_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lmfc_strobe |=> (lmfc_strobe || idx_o == IW'(1)));

endmodule

// File: rtl/lts_ila_builder.sv
module lts_ila_builder #(
    parameter int MF_LEN    = 16,
    parameter int CFG_BYTES = 8,
    parameter int MFW       = 3,
    localparam int IW = (MF_LEN > 1) ? $clog2(MF_LEN) : 1
) (
    input  logic [MFW-1:0]         mf_i,
    input  logic [IW-1:0]          idx_i,
    input  logic [CFG_BYTES*8-1:0] cfg_i,
    output logic [7:0]             ch_o,
    output logic                   k_o
);
    import lts_pkg::*;

    localparam logic [IW-1:0] LAST = IW'(MF_LEN - 1);

    logic [7:0] cfg_arr [CFG_BYTES];
    logic [7:0] cfg_sel;
    logic       cfg_hit;
    logic       second_mf;

    for (genvar gi = 0; gi < CFG_BYTES; gi++) begin : g_unpack
        assign cfg_arr[gi] = cfg_i[8*gi +: 8];
    end

    always_comb begin
        cfg_sel = 8'h00;
        cfg_hit = 1'b0;
        for (int i = 0; i < CFG_BYTES; i++) begin
            if (idx_i == IW'(i + 2)) begin
                cfg_sel = cfg_arr[i];
                cfg_hit = 1'b1;
            end
        end
    end

    assign second_mf = (mf_i == MFW'(1));

    always_comb begin
        ch_o = 8'(idx_i);
        k_o  = 1'b0;
        if (idx_i == '0) begin
            ch_o = CH_SOS;
            k_o  = 1'b1;
        end else if (idx_i == LAST) begin
            ch_o = CH_LANE;
            k_o  = 1'b1;
        end else if (second_mf && idx_i == IW'(1)) begin
            ch_o = CH_CFG;
            k_o  = 1'b1;
        end else if (second_mf && cfg_hit) begin
            ch_o = cfg_sel;
        end
    end

endmodule

// File: rtl/lane_tx_sequencer.sv
module lane_tx_sequencer #(
    parameter int OCTETS_PER_FRAME = 2,
    parameter int FRAMES_PER_MF    = 8,
    parameter int ILA_MULTIFRAMES  = 4,
    parameter int CFG_BYTES        = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sync_n,
    input  logic                   lmfc_strobe,
    input  logic                   frame_start,
    input  logic [7:0]             user_data,
    input  logic                   user_valid,
    input  logic [CFG_BYTES*8-1:0] cfg_bytes,
    output logic [7:0]             tx_char,
    output logic                   tx_is_k
);
    import lts_pkg::*;

    localparam int MF_LEN = OCTETS_PER_FRAME * FRAMES_PER_MF;
    localparam int IW     = (MF_LEN > 1) ? $clog2(MF_LEN) : 1;
    localparam int MFW    = $clog2(ILA_MULTIFRAMES + 1);
    localparam logic [IW-1:0]  LAST    = IW'(MF_LEN - 1);
    localparam logic [MFW-1:0] MF_LAST = MFW'(ILA_MULTIFRAMES - 1);

    if (ILA_MULTIFRAMES < 4 || CFG_BYTES + 3 > MF_LEN) begin : g_bad_params
        $error("lane_tx_sequencer: need ILA_MULTIFRAMES >= 4 and CFG_BYTES + 3 <= MF_LEN");
    end

    typedef struct packed {
        lts_state_e     state;
        logic [MFW-1:0] mf;
        logic [7:0]     ch;
        logic           k;
    } seq_t;

    seq_t r_q, r_d;

    logic [IW-1:0]  idx;
    logic [MFW-1:0] mf_sel;
    logic [7:0]     ila_ch;
    logic           ila_k;

    lts_mf_position #(.MF_LEN(MF_LEN)) u_pos (
        .clk        (clk),
        .rst_n      (rst_n),
        .lmfc_strobe(lmfc_strobe),
        .idx_o      (idx)
    );

    assign mf_sel = (r_q.state == ST_ILA) ? r_q.mf : '0;

    lts_ila_builder #(
        .MF_LEN   (MF_LEN),
        .CFG_BYTES(CFG_BYTES),
        .MFW      (MFW)
    ) u_ila (
        .mf_i (mf_sel),
        .idx_i(idx),
        .cfg_i(cfg_bytes),
        .ch_o (ila_ch),
        .k_o  (ila_k)
    );

    always_comb begin
        r_d    = r_q;
        r_d.ch = CH_COMMA;
        r_d.k  = 1'b1;
        if (!sync_n) begin
            r_d.state = ST_CGS;
            r_d.mf    = '0;
        end else begin
            unique case (r_q.state)
                ST_CGS: begin
                    r_d.state = ST_WAIT;
                end
                ST_WAIT: begin
                    if (lmfc_strobe) begin
                        r_d.state = ST_ILA;
                        r_d.mf    = '0;
                        r_d.ch    = ila_ch;
                        r_d.k     = ila_k;
                    end
                end
                ST_ILA: begin
                    r_d.ch = ila_ch;
                    r_d.k  = ila_k;
                    if (idx == LAST) begin
                        if (r_q.mf == MF_LAST) r_d.state = ST_DATA;
                        else                   r_d.mf    = r_q.mf + 1'b1;
                    end
                end
                ST_DATA: begin
                    r_d.ch = user_valid ? user_data : 8'h00;
                    r_d.k  = 1'b0;
                end
                default: r_d.state = ST_CGS;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= ST_CGS;
            r_q.mf    <= '0;
            r_q.ch    <= CH_COMMA;
            r_q.k     <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_char = r_q.ch;
    assign tx_is_k = r_q.k;

    p_sync_comma_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_n |=> (tx_char == CH_COMMA && tx_is_k));

    p_cgs_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_CGS) |=> (tx_char == CH_COMMA && tx_is_k));

    p_ila_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_WAIT && sync_n && lmfc_strobe) |=> (tx_char == CH_SOS && tx_is_k));

    p_boundary_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lmfc_strobe |-> frame_start);

    p_mf_tail_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_ILA && sync_n && idx == LAST) |=> (tx_char == CH_LANE && tx_is_k));

    p_data_plain_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_DATA && sync_n) |=> !tx_is_k);

endmodule

// File: tb/lane_tx_sequencer_bench.sv
`timescale 1ns/1ps
module lane_tx_sequencer_bench;
    localparam int OPF = 2;
    localparam int FPM = 5;
    localparam int MF  = OPF * FPM;
    localparam int NMF = 4;
    localparam int NCFG = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_n = 1'b0;
    logic lmfc_strobe = 1'b0;
    logic frame_start = 1'b0;
    logic [7:0] user_data = 8'h00;
    logic user_valid = 1'b0;
    logic [NCFG*8-1:0] cfg = 32'hA5_3C_81_7E;
    logic [7:0] tx_char;
    logic tx_is_k;

    int checks = 0;
    int errors = 0;
    int slot = 3;
    bit done = 1'b0;

    logic [8:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    lane_tx_sequencer #(
        .OCTETS_PER_FRAME(OPF),
        .FRAMES_PER_MF   (FPM),
        .ILA_MULTIFRAMES (NMF),
        .CFG_BYTES       (NCFG)
    ) u_lane_tx_sequencer (
        .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .lmfc_strobe(lmfc_strobe),
        .frame_start(frame_start), .user_data(user_data), .user_valid(user_valid),
        .cfg_bytes(cfg), .tx_char(tx_char), .tx_is_k(tx_is_k)
    );

    task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got char=%02h k=%0b, expected char=%02h k=%0b",
                     tag, act[8:1], act[0], exp[8:1], exp[0]);
        end
    endtask

    // monitor: one item per cycle, compared shortly after the edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [8:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, {tx_char, tx_is_k}, e);
        end
    end

    task automatic step(input logic s, input logic v, input logic [7:0] d,
                        input logic [7:0] ech, input logic ek, input string tag);
        @(negedge clk);
        sync_n      = s;
        user_valid  = v;
        user_data   = d;
        lmfc_strobe = (slot == 0);
        frame_start = (slot % OPF == 0);
        exp_q.push_back({ech, ek});
        tag_q.push_back(tag);
        slot = (slot + 1) % MF;
    endtask

    task automatic ila_exp(input int m, input int p, output logic [7:0] c,
                           output logic k, output string tag);
        if (p == 0)                 begin c = 8'h1C; k = 1; tag = "R5 start"; end
        else if (p == MF - 1)       begin c = 8'h7C; k = 1; tag = "R5 end"; end
        else if (m == 1 && p == 1)  begin c = 8'h9C; k = 1; tag = "R7 cfg marker"; end
        else if (m == 1 && p >= 2 && p < 2 + NCFG) begin
            c = cfg[8*(p-2) +: 8]; k = 0; tag = "R7 cfg byte";
        end else if (m == 1)        begin c = 8'(p); k = 0; tag = "R7 filler"; end
        else                        begin c = 8'(p); k = 0; tag = "R6 counter"; end
    endtask

    task automatic commas(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 8'h00, 8'hBC, 1'b1, "R1 sync low");
    endtask

    // releases sync; abort_m < 0 means run the full sequence
    task automatic handshake(input int abort_m, input int abort_p);
        step(1'b1, 1'b0, 8'h00, 8'hBC, 1'b1, "R3 first high");
        while (slot != 0) step(1'b1, 1'b0, 8'h00, 8'hBC, 1'b1, "R3 wait boundary");
        for (int m = 0; m < NMF; m++) begin
            for (int p = 0; p < MF; p++) begin
                logic [7:0] c; logic k; string t;
                if (m == abort_m && p == abort_p) begin
                    step(1'b0, 1'b0, 8'h00, 8'hBC, 1'b1, "R9 drop in sequence");
                    return;
                end
                ila_exp(m, p, c, k, t);
                step(1'b1, 1'b0, 8'h00, c, k, t);
            end
        end
    endtask

    task automatic data_run(input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            logic v; logic [7:0] d;
            v = ((i * 7 + seed) % 5) != 0;
            d = 8'((i * 37 + seed * 11) ^ 8'h5A);
            step(1'b1, v, d, v ? d : 8'h00, 1'b0, (i == 0) ? "R4 first data slot" : "R8 data");
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R2 in reset", {tx_char, tx_is_k}, {8'hBC, 1'b1});
        rst_n = 1'b1;
        step(1'b0, 1'b0, 8'h00, 8'hBC, 1'b1, "R2 after reset");
        commas(12);
        while (slot != 0) commas(1);
        // R3: sync first high in a boundary slot, that strobe must not count
        handshake(-1, 0);
        data_run(25, 1);
        // R9: drop during user data
        commas(7);
        while (slot != MF - 1) commas(1);
        // R3: release one slot before a boundary
        handshake(-1, 0);
        data_run(6, 2);
        commas(4);
        // R9: drop in the middle of the third multiframe, then full restart
        handshake(2, 5);
        commas(9);
        cfg = 32'h11_F0_0F_C3;
        handshake(-1, 0);
        data_run(30, 3);
        commas(3);
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule